// File: doc/BRIEF.md
# Dual-Width Static Memory Functional Model

This block is a synthesizable, clocked functional model of an asynchronous static memory. Its data port works either as one 16-bit word or as a single 8-bit byte, chosen by a width-select input. Two chip enables select the device. One is active-low and one is active-high. A read/write line, an output enable and two byte-lane controls decide, for each 8-bit lane, whether the model returns read data, takes write data, or leaves the lane floating.

The model has no real tri-state nets. Each lane has a drive-enable output, and its data-out lane reads zero while that enable is low, so a self-checking environment can see high impedance directly.

In byte mode the top data pin is no longer data. It becomes the least-significant bit of a byte address below the word address. That bit picks the low or high half of the addressed word. All byte-mode traffic uses the low lane only.

The storage is a parameterised array of byte-wide memories with synchronous read. Address bits above the array depth are ignored. Inputs are sampled on the rising clock edge. Writes take effect at that edge. Read data and lane drive enables appear one cycle later.

Top module: `dw_sram_model`

## Requirements
- R1: When the device is not selected, no lane is driven in the following cycle and no write takes place. Selection means `ce_n`=0 and `ce`=1; every other combination of the two enables is not selected.
- R2: In word mode (`wide`=1) with `lb_n`=1 and `ub_n`=1, the device is in standby. No lane is driven and nothing is written, whatever `oe_n` and `wr_n` are.
- R3: A word-mode read needs selection, `oe_n`=0 and `wr_n`=1. One cycle later lane 0 (`dq_out[7:0]`) is driven exactly when `lb_n`=0, and lane 1 (`dq_out[15:8]`) exactly when `ub_n`=0. A driven lane carries the stored byte of that lane at the word address.
- R4: A word-mode write needs selection and `wr_n`=0, and ignores `oe_n`. Lane 0 is written from `dq_in[7:0]` only when `lb_n`=0. Lane 1 is written from `dq_in[15:8]` only when `ub_n`=0. Unwritten lanes keep their contents.
- R5: Output deselect: selected with `wr_n`=1 and `oe_n`=1 drives no lane, for every value of the byte controls.
- R6: In the cycle after a write cycle, no lane is driven.
- R7: Byte-mode read (`wide`=0):
  - Only lane 0 is driven, whatever `lb_n` and `ub_n` are, both high included.
  - `dq_out[7:0]` carries the low half of the addressed word when `dq_in[15]`=0, and the high half when `dq_in[15]`=1.
- R8: Byte-mode write: `dq_in[7:0]` goes into the low half of the word when `dq_in[15]`=0, and into the high half when it is 1. The other half is unchanged, and the byte controls have no effect.
- R9: Only the low `DEPTH_LOG2` bits of `addr` select a word; higher address bits have no effect.
- R10: After reset, `lane_oe` and `dq_out` are all zero.
- R11: Any lane whose drive enable is low presents zero on its `dq_out` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| oe_n | input | 1 | Active-low output enable |
| wr_n | input | 1 | Read/write line: 1 read, 0 write |
| wide | input | 1 | Width select: 1 word mode, 0 byte mode |
| lb_n | input | 1 | Active-low lower lane control (word mode) |
| ub_n | input | 1 | Active-low upper lane control (word mode) |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data; bit 15 is the low byte-address bit in byte mode |
| dq_out | output | 16 | Read data, zero on undriven lanes |
| lane_oe | output | 2 | Per-lane drive enable (bit 0 low lane, bit 1 high lane) |

## Verification
The bench builds the block with `ADDR_W`=8 and `DEPTH_LOG2`=4. The array is then only 16 words, so every word and every byte half can be written and read back in both modes. The same sweep can run each deselect and standby combination against every address.

The upper four address bits lie above the array index. Driving them with changing values makes the aliasing of truncated addresses visible at the ports.

// File: rtl/dw_sram_pkg.sv
package dw_sram_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef struct packed {
    logic             rd;
    logic             wr;
    logic             byte_mode;
    logic [LANES-1:0] rd_lanes;
    logic [LANES-1:0] wr_lanes;
  } dw_ctl_t;
endpackage

// File: rtl/dw_sram_decode.sv
module dw_sram_decode
  import dw_sram_pkg::*;
(
  input  logic    ce_n,
  input  logic    ce,
  input  logic    oe_n,
  input  logic    wr_n,
  input  logic    wide,
  input  logic    lb_n,
  input  logic    ub_n,
  input  logic    half,
  output dw_ctl_t ctl
);
  logic             selected;
  logic             lanes_off;
  logic             active;
  logic [LANES-1:0] lane_use;
  logic [LANES-1:0] byte_wmask;

  always_comb begin
    selected   = !ce_n && ce;
    lanes_off  = wide && lb_n && ub_n;
    active     = selected && !lanes_off;
    lane_use   = wide ? {!ub_n, !lb_n} : {1'b0, 1'b1};
    byte_wmask = half ? {1'b1, 1'b0} : {1'b0, 1'b1};

    ctl.byte_mode = !wide;
    ctl.rd        = active && wr_n && !oe_n;
    ctl.wr        = active && !wr_n;
    ctl.rd_lanes  = ctl.rd ? lane_use : '0;
    ctl.wr_lanes  = !ctl.wr ? '0 : (wide ? lane_use : byte_wmask);
  end
endmodule

// File: rtl/dw_sram_steer.sv
module dw_sram_steer
  import dw_sram_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     dq_in,
  input  logic                  byte_mode,
  output logic [DEPTH_LOG2-1:0] idx,
  output logic                  half,
  output logic [DATA_W-1:0]     wdata
);
  assign idx  = addr[DEPTH_LOG2-1:0];
  assign half = dq_in[DATA_W-1];

  generate
    if (ADDR_W > DEPTH_LOG2) begin : g_trunc
      logic unused_hi_addr;
      assign unused_hi_addr = ^addr[ADDR_W-1:DEPTH_LOG2];
    end
  endgenerate

  always_comb begin
    wdata[LANE_W-1:0] = dq_in[LANE_W-1:0];
    wdata[DATA_W-1:LANE_W] = byte_mode ? dq_in[LANE_W-1:0]
                                       : dq_in[DATA_W-1:LANE_W];
  end
endmodule

// File: rtl/dw_sram_array.sv
module dw_sram_array
  import dw_sram_pkg::*;
#(
  parameter int DEPTH_LOG2 = 10
) (
  input  logic                  clk,
  input  logic [DEPTH_LOG2-1:0] idx,
  input  logic [LANES-1:0]      we,
  input  logic                  re,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] q;

      always_ff @(posedge clk) begin
        if (we[g]) mem[idx] <= wdata[g*LANE_W +: LANE_W];
        if (re)    q <= mem[idx];
      end

      assign rdata[g*LANE_W +: LANE_W] = q;
    end
  endgenerate
endmodule

// File: rtl/dw_sram_model.sv
module dw_sram_model
  import dw_sram_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              ce,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic              wide,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  lane_oe
);
  dw_ctl_t               ctl;
  logic [DEPTH_LOG2-1:0] idx;
  logic                  half;
  logic [DATA_W-1:0]     wdata;
  logic [DATA_W-1:0]     rdata;
  logic [LANES-1:0]      lane_oe_q;
  logic                  half_q;
  logic                  byte_q;

  dw_sram_decode u_decode (
    .ce_n (ce_n),
    .ce   (ce),
    .oe_n (oe_n),
    .wr_n (wr_n),
    .wide (wide),
    .lb_n (lb_n),
    .ub_n (ub_n),
    .half (half),
    .ctl  (ctl)
  );

  dw_sram_steer #(
    .ADDR_W     (ADDR_W),
    .DEPTH_LOG2 (DEPTH_LOG2)
  ) u_steer (
    .addr      (addr),
    .dq_in     (dq_in),
    .byte_mode (ctl.byte_mode),
    .idx       (idx),
    .half      (half),
    .wdata     (wdata)
  );

  dw_sram_array #(
    .DEPTH_LOG2 (DEPTH_LOG2)
  ) u_array (
    .clk   (clk),
    .idx   (idx),
    .we    (ctl.wr_lanes),
    .re    (ctl.rd),
    .wdata (wdata),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_oe_q <= '0;
      half_q    <= 1'b0;
      byte_q    <= 1'b0;
    end else begin
      lane_oe_q <= ctl.rd_lanes;
      half_q    <= half;
      byte_q    <= ctl.byte_mode;
    end
  end

  always_comb begin
    logic [LANE_W-1:0] low_sel;
    low_sel = (byte_q && half_q) ? rdata[DATA_W-1:LANE_W] : rdata[LANE_W-1:0];
    dq_out[LANE_W-1:0]      = lane_oe_q[0] ? low_sel : '0;
    dq_out[DATA_W-1:LANE_W] = lane_oe_q[1] ? rdata[DATA_W-1:LANE_W] : '0;
  end

  assign lane_oe = lane_oe_q;
endmodule

// File: rtl/dw_sram_chk.sv
module dw_sram_chk
  import dw_sram_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              ce,
  input logic              oe_n,
  input logic              wr_n,
  input logic              wide,
  input logic              lb_n,
  input logic              ub_n,
  input logic [DATA_W-1:0] dq_out,
  input logic [LANES-1:0]  lane_oe
);
  a_r1_unselected_floats: assert property (@(posedge clk) disable iff (rst)
    !(!ce_n && ce) |=> lane_oe == '0);

  a_r2_both_lanes_off_floats: assert property (@(posedge clk) disable iff (rst)
    (wide && lb_n && ub_n) |=> lane_oe == '0);

  a_r3_word_read_lanes: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && ce && wide && wr_n && !oe_n) |=>
      lane_oe == {!$past(ub_n), !$past(lb_n)});

  a_r5_output_deselect: assert property (@(posedge clk) disable iff (rst)
    (wr_n && oe_n) |=> lane_oe == '0);

  a_r6_write_floats: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> lane_oe == '0);

  a_r7_byte_mode_low_lane_only: assert property (@(posedge clk) disable iff (rst)
    !wide |=> !lane_oe[1]);

  a_r11_idle_lane_zero_low: assert property (@(posedge clk) disable iff (rst)
    !lane_oe[0] |-> dq_out[LANE_W-1:0] == '0);

  a_r11_idle_lane_zero_high: assert property (@(posedge clk) disable iff (rst)
    !lane_oe[1] |-> dq_out[DATA_W-1:LANE_W] == '0);
endmodule

bind dw_sram_model dw_sram_chk u_chk (.*);

// File: tb/tb_dw_sram_model.sv
module tb_dw_sram_model;
  localparam int AW = 8;
  localparam int DL = 4;
  localparam int N  = 1 << DL;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          ce_n, ce, oe_n, wr_n, wide, lb_n, ub_n;
  logic [AW-1:0] addr;
  logic [15:0]   dq_in;
  logic [15:0]   dq_out;
  logic [1:0]    lane_oe;

  logic [15:0] sh [N];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dw_sram_model #(.ADDR_W(AW), .DEPTH_LOG2(DL)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .ce(ce), .oe_n(oe_n), .wr_n(wr_n),
    .wide(wide), .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .lane_oe(lane_oe)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic cen, input logic cee, input logic oen,
                     input logic wrn, input logic wd, input logic lbn,
                     input logic ubn, input logic [AW-1:0] a,
                     input logic [15:0] d);
    ce_n = cen; ce = cee; oe_n = oen; wr_n = wrn; wide = wd;
    lb_n = lbn; ub_n = ubn; addr = a; dq_in = d;
    @(negedge clk);
  endtask

  task automatic wwrite(input logic [AW-1:0] a, input logic [15:0] d,
                        input logic lbn, input logic ubn, input logic oen);
    cyc(1'b0, 1'b1, oen, 1'b0, 1'b1, lbn, ubn, a, d);
    chk(lane_oe == 2'b00, "R6 word write floats", {14'b0, lane_oe}, 16'h0);
    if (!lbn) sh[a[DL-1:0]][7:0]  = d[7:0];
    if (!ubn) sh[a[DL-1:0]][15:8] = d[15:8];
  endtask

  task automatic wread(input logic [AW-1:0] a, input logic lbn,
                       input logic ubn, input string tag);
    logic [15:0] e;
    logic [1:0]  eoe;
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, lbn, ubn, a, 16'h0);
    e   = sh[a[DL-1:0]];
    eoe = {!ubn, !lbn};
    chk(lane_oe == eoe, tag, {14'b0, lane_oe}, {14'b0, eoe});
    chk(dq_out == {eoe[1] ? e[15:8] : 8'h00, eoe[0] ? e[7:0] : 8'h00},
        tag, dq_out, {eoe[1] ? e[15:8] : 8'h00, eoe[0] ? e[7:0] : 8'h00});
  endtask

  task automatic bwrite(input logic [AW-1:0] a, input logic h,
                        input logic [7:0] d, input logic lbn, input logic ubn);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, lbn, ubn, a, {h, 7'h2A, d});
    chk(lane_oe == 2'b00, "R6 byte write floats", {14'b0, lane_oe}, 16'h0);
    if (h) sh[a[DL-1:0]][15:8] = d;
    else   sh[a[DL-1:0]][7:0]  = d;
  endtask

  task automatic bread(input logic [AW-1:0] a, input logic h,
                       input logic lbn, input logic ubn);
    logic [15:0] e;
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, lbn, ubn, a, {h, 15'h3C3C});
    e = sh[a[DL-1:0]];
    chk(lane_oe == 2'b01, "R7 byte read lanes", {14'b0, lane_oe}, 16'h1);
    chk(dq_out == {8'h00, h ? e[15:8] : e[7:0]}, "R7 byte read data",
        dq_out, {8'h00, h ? e[15:8] : e[7:0]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    ce_n = 1'b1; ce = 1'b0; oe_n = 1'b1; wr_n = 1'b1; wide = 1'b1;
    lb_n = 1'b1; ub_n = 1'b1; addr = '0; dq_in = '0;
    for (int i = 0; i < N; i++) sh[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(lane_oe == 2'b00, "R10 reset lane_oe", {14'b0, lane_oe}, 16'h0);
    chk(dq_out == 16'h0, "R10 reset dq_out", dq_out, 16'h0);
    rst = 1'b0;
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    chk(lane_oe == 2'b00, "R10 idle after reset", {14'b0, lane_oe}, 16'h0);

    // R4: full word writes, oe_n toggled to show it is ignored
    for (int i = 0; i < N; i++)
      wwrite(AW'(i), {8'(i * 37 + 5), 8'(i * 11 + 200)}, 1'b0, 1'b0, i[0]);
    // R3: full word reads
    for (int i = 0; i < N; i++) wread(AW'(i), 1'b0, 1'b0, "R3 word read");

    // R4: single-lane writes leave the other lane untouched
    for (int i = 0; i < N; i++)
      wwrite(AW'(i), {8'(i * 5 + 17), 8'(i * 3 + 99)}, i[0], !i[0], i[1]);
    for (int i = 0; i < N; i++) wread(AW'(i), 1'b0, 1'b0, "R4 lane write");

    // R3/R11: single-lane reads, undriven lane reads zero
    for (int i = 0; i < N; i++) begin
      wread(AW'(i), 1'b0, 1'b1, "R11 low lane only");
      wread(AW'(i), 1'b1, 1'b0, "R11 high lane only");
    end

    // R1: unselected combinations neither drive nor write
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < 3; c++) begin
        logic cn, cp;
        cn = (c != 1);
        cp = (c == 0);
        cyc(cn, cp, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(i), 16'hDEAD);
        chk(lane_oe == 2'b00, "R1 unselected write", {14'b0, lane_oe}, 16'h0);
        cyc(cn, cp, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, AW'(i), 16'h0);
        chk(lane_oe == 2'b00, "R1 unselected read", {14'b0, lane_oe}, 16'h0);
        chk(dq_out == 16'h0, "R1 unselected data", dq_out, 16'h0);
      end
      wread(AW'(i), 1'b0, 1'b0, "R1 contents kept");
    end

    // R2: both byte controls high in word mode is standby
    for (int i = 0; i < N; i++) begin
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, AW'(i), 16'hBEEF);
      chk(lane_oe == 2'b00, "R2 standby write", {14'b0, lane_oe}, 16'h0);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, AW'(i), 16'h0);
      chk(lane_oe == 2'b00, "R2 standby read", {14'b0, lane_oe}, 16'h0);
      wread(AW'(i), 1'b0, 1'b0, "R2 contents kept");
    end

    // R5: output deselect for every byte-control pattern
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 4; m++) begin
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, m[0], m[1], AW'(i), 16'h0);
        chk(lane_oe == 2'b00, "R5 deselect lanes", {14'b0, lane_oe}, 16'h0);
        chk(dq_out == 16'h0, "R5 deselect data", dq_out, 16'h0);
      end
    end

    // R8: byte writes touch only the selected half, byte controls ignored
    for (int i = 0; i < N; i++) begin
      for (int h = 0; h < 2; h++) begin
        bwrite(AW'(i), h[0], 8'(i * 7 + h * 100 + 3), i[0], i[1]);
        wread(AW'(i), 1'b0, 1'b0, "R8 byte write");
      end
    end

    // R7: byte reads of both halves, all byte-control patterns
    for (int i = 0; i < N; i++)
      for (int h = 0; h < 2; h++) bread(AW'(i), h[0], i[0], i[1]);

    // R9: high address bits alias onto the same word
    for (int i = 0; i < N; i++) begin
      wwrite({4'(i ^ 5), 4'(i)}, {8'(i * 13 + 1), 8'(i * 29 + 7)}, 1'b0, 1'b0, 1'b0);
      wread({4'(i ^ 10), 4'(i)}, 1'b0, 1'b0, "R9 alias read");
      wread(AW'(i), 1'b0, 1'b0, "R9 base read");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule